// File: doc/BRIEF.md
# DAC Sample Write Framer

This block is a write-only two-wire bus master that turns one sample word into one complete bus frame for a digital-to-analog converter. A waveform source presents a sample and pulses a start strobe. The block then sends a start condition, the device address byte with the direction bit set to write, an optional register-select byte, and one or two data bytes. A stop condition ends the frame. The block pulses a completion flag so that the source can offer the next sample at once. Every frame therefore carries a single converter update.

The bus clock is derived from the system clock through a quarter-period divider. A floor on the divider comes from the system clock rate and the maximum bus rate, so a divider value that is too small cannot push the bus clock past its limit. Both bus lines are open-drain: the block only ever pulls a line low or releases it. The data line is read back so the block can sample the receiver's acknowledge. When an acknowledge is missing, the frame is cut short with a stop and an error flag is raised.

Top module: `dac_wr_framer`

## Requirements
- R1: While reset is held and right after it, both line pull-downs are inactive (lines released) and `busy_o`, `done_o` and `nack_o` are low.
- R2: Each frame opens with exactly one start (SDA falls while SCL is high) and closes with exactly one stop (SDA rises while SCL is high). Apart from these two events, SDA changes only while the block holds SCL low.
- R3: The first byte of every frame is the 7-bit device address followed by a 0 in the least significant position, which is the write direction bit.
- R4: When `sub_en_i` is 1, the second byte is `sub_addr_i`. When it is 0, no register-select byte is sent and data follows the address byte directly.
- R5: When `wide_en_i` is 1, the sample is zero-extended to 16 bits and sent as two bytes, upper byte first. When it is 0, one byte is sent, holding the sample's 8 most significant bits. Every byte is sent most significant bit first.
- R6: During the ninth clock of each byte the block releases SDA and samples it. A high level there ends the frame with a stop and sends no further bytes, and it sets `nack_o`. `nack_o` returns low when the next frame is accepted.
- R7: Each SCL high phase inside a frame lasts 2*D system clocks, where D is the larger of the captured `div_i` and MIN_DIV = ceil(CLK_HZ / (4*SCL_MAX_HZ)). MIN_DIV is 13 with the default 20 MHz clock and a 400 kHz limit.
- R8: `busy_o` goes high the cycle after a start strobe is accepted. `done_o` is a single-cycle pulse that rises one clock after SDA is released in the stop condition, in the same cycle that `busy_o` falls. The pulse also appears after an aborted frame.
- R9: A start strobe that arrives while `busy_o` is high is ignored. The sample, addresses, mode bits and divider are captured when the frame is accepted, so later changes to them do not affect the frame in flight.
- R10: Between frames both lines stay released and no SCL pulses are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one frame; accepted only when idle |
| sample_i | input | SAMPLE_W | Sample word to send |
| dev_addr_i | input | 7 | Device address |
| sub_addr_i | input | 8 | Register-select byte |
| sub_en_i | input | 1 | 1: send the register-select byte |
| wide_en_i | input | 1 | 1: two data bytes, 0: one data byte |
| div_i | input | DIV_W | Quarter bus-period length in system clocks (clamped to MIN_DIV) |
| sda_i | input | 1 | Data line level read back |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| nack_o | output | 1 | Last frame ended on a missing acknowledge |

## Verification
On every cycle, the assertions check the following: SDA moves in the data phase only while SCL is held low, SDA is released in the acknowledge slot, a missing acknowledge leads straight to the stop phase with the error flag set, and the completion pulse lasts one cycle and never overlaps `busy_o`. They also check that both lines are released in idle and that the captured sample stays frozen for the whole frame. Only the bench scenarios can show the byte contents and their order under each mode, the exact SCL high width including the divider floor, and the one-clock spacing between stop and completion. The same holds for a stray start strobe and for mid-frame input changes, whose lack of effect shows only in the bytes that reach the bus.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_BIT   = 3'd2,
      ST_STOP  = 3'd3,
      ST_FIN   = 3'd4
   } dwf_state_e;

   localparam int BYTE_W    = 8;
   localparam int WIDE_W    = 16;
   localparam int SLOT_ACK  = 8;

endpackage

// File: rtl/dwf_tick_gen.sv
module dwf_tick_gen #(
   parameter int DIV_W   = 8,
   parameter int MIN_DIV = 13
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   localparam logic [DIV_W-1:0] MIN_D = MIN_DIV[DIV_W-1:0];

   if (MIN_DIV < 2) begin : g_bad_min
      $error("dwf_tick_gen: MIN_DIV must be at least 2");
   end
   if (MIN_DIV >= (1 << DIV_W)) begin : g_bad_width
      $error("dwf_tick_gen: MIN_DIV does not fit in DIV_W bits");
   end

   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   // floor keeps the bus clock at or below its limit
   assign div_eff = (div_i < MIN_D) ? MIN_D : div_i;
   assign wrap    = (cnt_q >= div_eff - 1'b1);
   assign tick_o  = run_i && wrap;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         cnt_q <= '0;
      end else if (!run_i || wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // quarter ticks are at least two clocks apart
   assert_tick_spacing_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      tick_o |=> !tick_o);

endmodule

// File: rtl/dwf_byte_sel.sv
module dwf_byte_sel #(
   parameter int SAMPLE_W = 12
) (
   input  logic [1:0]          byte_idx_i,
   input  logic [6:0]          dev_addr_i,
   input  logic [7:0]          sub_addr_i,
   input  logic                sub_en_i,
   input  logic                wide_en_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   output logic [7:0]          byte_o,
   output logic                last_o
);

   import dwf_pkg::*;

   if (SAMPLE_W < BYTE_W || SAMPLE_W > WIDE_W) begin : g_bad_sample
      $error("dwf_byte_sel: SAMPLE_W must lie between 8 and 16");
   end

   logic [WIDE_W-1:0] wide;
   logic [7:0]        top8;
   logic [2:0]        n_bytes;
   logic [1:0]        dslot;

   if (SAMPLE_W == WIDE_W) begin : g_full
      assign wide = sample_i;
   end else begin : g_pad
      assign wide = {{(WIDE_W-SAMPLE_W){1'b0}}, sample_i};
   end

   assign top8    = sample_i[SAMPLE_W-1 -: BYTE_W];
   assign n_bytes = 3'd2 + {2'b00, sub_en_i} + {2'b00, wide_en_i};
   assign last_o  = ({1'b0, byte_idx_i} == n_bytes - 3'd1);
   assign dslot   = sub_en_i ? (byte_idx_i - 2'd2) : (byte_idx_i - 2'd1);

   always_comb begin
      if (byte_idx_i == 2'd0) begin
         byte_o = {dev_addr_i, 1'b0};
      end else if (sub_en_i && byte_idx_i == 2'd1) begin
         byte_o = sub_addr_i;
      end else if (dslot == 2'd0) begin
         byte_o = wide_en_i ? wide[15:8] : top8;
      end else begin
         byte_o = wide[7:0];
      end
   end

endmodule

// File: rtl/dwf_ctrl.sv
module dwf_ctrl (
   input  logic       clk_i,
   input  logic       rst_n_i,
   input  logic       start_i,
   input  logic       tick_i,
   input  logic [7:0] byte_i,
   input  logic       last_i,
   input  logic       sda_i,
   output logic       accept_o,
   output logic       run_o,
   output logic [1:0] byte_idx_o,
   output logic       scl_oe_o,
   output logic       sda_oe_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       nack_o
);

   import dwf_pkg::*;

   dwf_state_e state_q;
   logic [1:0] phase_q;
   logic [3:0] slot_q;
   logic [7:0] shift_q;
   logic [1:0] bidx_q;
   logic       last_q;
   logic       ack_bad_q;
   logic       scl_oe_q;
   logic       sda_oe_q;
   logic       done_q;
   logic       nack_q;
   logic       in_ack;

   assign in_ack     = slot_q[3];
   assign accept_o   = (state_q == ST_IDLE) && start_i;
   assign run_o      = (state_q == ST_START) || (state_q == ST_BIT) || (state_q == ST_STOP);
   assign byte_idx_o = bidx_q;
   assign scl_oe_o   = scl_oe_q;
   assign sda_oe_o   = sda_oe_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign nack_o     = nack_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         state_q   <= ST_IDLE;
         phase_q   <= 2'd0;
         slot_q    <= 4'd0;
         shift_q   <= 8'd0;
         bidx_q    <= 2'd0;
         last_q    <= 1'b0;
         ack_bad_q <= 1'b0;
         scl_oe_q  <= 1'b0;
         sda_oe_q  <= 1'b0;
         done_q    <= 1'b0;
         nack_q    <= 1'b0;
      end else begin
         done_q <= (state_q == ST_FIN);
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q   <= ST_START;
                  phase_q   <= 2'd0;
                  bidx_q    <= 2'd0;
                  nack_q    <= 1'b0;
                  ack_bad_q <= 1'b0;
               end
            end
            ST_START: begin
               if (tick_i) begin
                  if (phase_q == 2'd0) begin
                     sda_oe_q <= 1'b1;          // SDA falls, SCL high
                     phase_q  <= 2'd1;
                  end else begin
                     scl_oe_q <= 1'b1;
                     state_q  <= ST_BIT;
                     phase_q  <= 2'd0;
                     shift_q  <= byte_i;
                     slot_q   <= 4'd0;
                  end
               end
            end
            ST_BIT: begin
               if (tick_i) begin
                  unique case (phase_q)
                     2'd0: begin
                        sda_oe_q <= in_ack ? 1'b0 : ~shift_q[7];
                        if (in_ack) begin
                           last_q <= last_i;
                           bidx_q <= bidx_q + 2'd1;
                        end
                        phase_q <= 2'd1;
                     end
                     2'd1: begin
                        scl_oe_q <= 1'b0;
                        phase_q  <= 2'd2;
                     end
                     2'd2: begin
                        if (in_ack) begin
                           ack_bad_q <= sda_i;
                        end
                        phase_q <= 2'd3;
                     end
                     default: begin
                        scl_oe_q <= 1'b1;
                        phase_q  <= 2'd0;
                        if (!in_ack) begin
                           shift_q <= {shift_q[6:0], 1'b0};
                           slot_q  <= slot_q + 4'd1;
                        end else if (ack_bad_q || last_q) begin
                           state_q <= ST_STOP;
                           nack_q  <= ack_bad_q;
                        end else begin
                           shift_q <= byte_i;
                           slot_q  <= 4'd0;
                        end
                     end
                  endcase
               end
            end
            ST_STOP: begin
               if (tick_i) begin
                  unique case (phase_q)
                     2'd0: begin
                        sda_oe_q <= 1'b1;
                        phase_q  <= 2'd1;
                     end
                     2'd1: begin
                        scl_oe_q <= 1'b0;
                        phase_q  <= 2'd2;
                     end
                     default: begin
                        sda_oe_q <= 1'b0;          // SDA rises, SCL high
                        state_q  <= ST_FIN;
                        phase_q  <= 2'd0;
                     end
                  endcase
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assert_sda_under_low_scl_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ((state_q == ST_BIT) && !$stable(sda_oe_q)) |-> (scl_oe_q && $past(scl_oe_q)));

   assert_ack_slot_release_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ((state_q == ST_BIT) && in_ack && (phase_q != 2'd0)) |-> !sda_oe_q);

   assert_nack_to_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ((state_q == ST_BIT) && tick_i && (phase_q == 2'd3) && in_ack && ack_bad_q)
      |=> ((state_q == ST_STOP) && nack_q));

   assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_q |=> !done_q);

   assert_idle_released_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (state_q == ST_IDLE) |-> (!scl_oe_q && !sda_oe_q));

endmodule

// File: rtl/dac_wr_framer.sv
module dac_wr_framer #(
   parameter int SAMPLE_W   = 12,
   parameter int DIV_W      = 8,
   parameter int CLK_HZ     = 20_000_000,
   parameter int SCL_MAX_HZ = 400_000
) (
   input  logic                clk_i,
   input  logic                rst_n_i,
   input  logic                start_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic [6:0]          dev_addr_i,
   input  logic [7:0]          sub_addr_i,
   input  logic                sub_en_i,
   input  logic                wide_en_i,
   input  logic [DIV_W-1:0]    div_i,
   input  logic                sda_i,
   output logic                scl_oe_o,
   output logic                sda_oe_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                nack_o
);

   localparam int QUARTER_HZ = 4 * SCL_MAX_HZ;
   localparam int MIN_DIV    = (CLK_HZ + QUARTER_HZ - 1) / QUARTER_HZ;

   if (SCL_MAX_HZ <= 0 || CLK_HZ < 8 * SCL_MAX_HZ) begin : g_bad_rates
      $error("dac_wr_framer: clock too slow for the requested bus rate");
   end

   logic                accept;
   logic                run;
   logic                tick;
   logic [1:0]          byte_idx;
   logic [7:0]          cur_byte;
   logic                last_byte;
   logic [SAMPLE_W-1:0] smp_q;
   logic [6:0]          addr_q;
   logic [7:0]          sub_q;
   logic                sub_en_q;
   logic                wide_en_q;
   logic [DIV_W-1:0]    div_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         smp_q     <= '0;
         addr_q    <= '0;
         sub_q     <= '0;
         sub_en_q  <= 1'b0;
         wide_en_q <= 1'b0;
         div_q     <= '0;
      end else if (accept) begin
         smp_q     <= sample_i;
         addr_q    <= dev_addr_i;
         sub_q     <= sub_addr_i;
         sub_en_q  <= sub_en_i;
         wide_en_q <= wide_en_i;
         div_q     <= div_i;
      end
   end

   dwf_tick_gen #(
      .DIV_W   (DIV_W),
      .MIN_DIV (MIN_DIV)
   ) i_tick (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .run_i   (run),
      .div_i   (div_q),
      .tick_o  (tick)
   );

   dwf_byte_sel #(
      .SAMPLE_W (SAMPLE_W)
   ) i_sel (
      .byte_idx_i (byte_idx),
      .dev_addr_i (addr_q),
      .sub_addr_i (sub_q),
      .sub_en_i   (sub_en_q),
      .wide_en_i  (wide_en_q),
      .sample_i   (smp_q),
      .byte_o     (cur_byte),
      .last_o     (last_byte)
   );

   dwf_ctrl i_ctrl (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .start_i    (start_i),
      .tick_i     (tick),
      .byte_i     (cur_byte),
      .last_i     (last_byte),
      .sda_i      (sda_i),
      .accept_o   (accept),
      .run_o      (run),
      .byte_idx_o (byte_idx),
      .scl_oe_o   (scl_oe_o),
      .sda_oe_o   (sda_oe_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .nack_o     (nack_o)
   );

   assert_frozen_sample_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $past(busy_o) |-> $stable(smp_q));

   assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_o |-> !busy_o);

endmodule

// File: tb/test_dac_wr_framer.sv
module test_dac_wr_framer;

   localparam int CLK_PERIOD = 10;
   localparam int SAMPLE_W   = 12;
   localparam int DIV_W      = 8;
   localparam int MIN_DIV    = 13;

   logic                clk;
   logic                rst_n;
   logic                start;
   logic [SAMPLE_W-1:0] sample;
   logic [6:0]          dev_addr;
   logic [7:0]          sub_addr;
   logic                sub_en;
   logic                wide_en;
   logic [DIV_W-1:0]    div;
   logic                sda_line;
   logic                scl_line;
   logic                scl_oe;
   logic                sda_oe;
   logic                busy;
   logic                done;
   logic                nack;
   logic                slave_low;

   int n_checks = 0;
   int n_errors = 0;

   dac_wr_framer #(
      .SAMPLE_W (SAMPLE_W),
      .DIV_W    (DIV_W)
   ) i_dac_wr_framer (
      .clk_i      (clk),
      .rst_n_i    (rst_n),
      .start_i    (start),
      .sample_i   (sample),
      .dev_addr_i (dev_addr),
      .sub_addr_i (sub_addr),
      .sub_en_i   (sub_en),
      .wide_en_i  (wide_en),
      .div_i      (div),
      .sda_i      (sda_line),
      .scl_oe_o   (scl_oe),
      .sda_oe_o   (sda_oe),
      .busy_o     (busy),
      .done_o     (done),
      .nack_o     (nack)
   );

   assign scl_line = ~scl_oe;
   assign sda_line = ~(sda_oe | slave_low);

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- bus monitor and acknowledging receiver ----------------
   int       cyc = 0;
   int       n_start, n_stop, n_rx, bitc, nack_at;
   int       hi_begin, hi_min, hi_max, high_moves;
   int       done_cnt, done_cyc, stop_cyc, done_busy;
   bit       hi_valid;
   logic [7:0] sr;
   logic [7:0] rx [0:7];
   logic     p_scl = 1'b1, p_sda = 1'b1, p_scl_oe = 1'b0, p_sda_oe = 1'b0;

   task automatic clr_mon(input int nack_byte);
      n_start = 0; n_stop = 0; n_rx = 0; bitc = 0; nack_at = nack_byte;
      hi_min = 1_000_000; hi_max = 0; high_moves = 0; hi_valid = 1'b0;
      done_cnt = 0; done_cyc = -100; stop_cyc = -100; done_busy = 0;
   endtask

   initial begin
      slave_low = 1'b0;
      clr_mon(-1);
   end

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (sda_oe != p_sda_oe && !scl_oe && !p_scl_oe) high_moves = high_moves + 1;
      if (scl_line && p_scl && !sda_line && p_sda) begin
         n_start = n_start + 1; n_rx = 0; bitc = 0; hi_valid = 1'b0;
      end
      if (scl_line && p_scl && sda_line && !p_sda) begin
         n_stop = n_stop + 1; stop_cyc = cyc;
      end
      if (scl_line && !p_scl) begin
         hi_begin = cyc; hi_valid = 1'b1;
         if (bitc < 8) begin
            sr = {sr[6:0], sda_line};
            bitc = bitc + 1;
            if (bitc == 8) begin
               if (n_rx < 8) rx[n_rx] = sr;
               n_rx = n_rx + 1;
            end
         end
      end
      if (!scl_line && p_scl) begin
         if (hi_valid) begin
            if (cyc - hi_begin < hi_min) hi_min = cyc - hi_begin;
            if (cyc - hi_begin > hi_max) hi_max = cyc - hi_begin;
         end
         if (bitc == 8) begin
            bitc = 9;
            slave_low = ((n_rx - 1) != nack_at);
         end else if (bitc == 9) begin
            bitc = 0;
            slave_low = 1'b0;
         end
      end
      if (done) begin
         done_cnt = done_cnt + 1; done_cyc = cyc;
         if (busy) done_busy = done_busy + 1;
      end
      p_scl = scl_line; p_sda = sda_line; p_scl_oe = scl_oe; p_sda_oe = sda_oe;
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_checks = n_checks + 1;
      if (act != exp) begin
         n_errors = n_errors + 1;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   logic [7:0] exp_b [0:7];
   int         exp_n;
   int         exp_d;
   bit         exp_nack;

   task automatic launch(input logic [6:0] a, input logic [7:0] s, input logic se,
                         input logic we, input logic [SAMPLE_W-1:0] smp,
                         input logic [DIV_W-1:0] dv, input int nack_byte);
      int k;
      logic [15:0] w;
      @(negedge clk);
      clr_mon(nack_byte);
      dev_addr = a; sub_addr = s; sub_en = se; wide_en = we; sample = smp; div = dv;
      exp_b[0] = {a, 1'b0};
      k = 1;
      if (se) begin exp_b[k] = s; k = k + 1; end
      w = 16'(smp);
      if (we) begin
         exp_b[k] = w[15:8]; exp_b[k+1] = w[7:0]; k = k + 2;
      end else begin
         exp_b[k] = smp[SAMPLE_W-1 -: 8]; k = k + 1;
      end
      exp_n    = (nack_byte >= 0) ? nack_byte + 1 : k;
      exp_nack = (nack_byte >= 0);
      exp_d    = (int'(dv) < MIN_DIV) ? MIN_DIV : int'(dv);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8", "busy after accept", busy, 1);
   endtask

   task automatic wait_done();
      while (done_cnt == 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic verify(input string tag);
      chk("R2", {tag, " start count"}, n_start, 1);
      chk("R2", {tag, " stop count"}, n_stop, 1);
      chk("R2", {tag, " SDA moves under high SCL"}, high_moves, 2);
      chk("R5", {tag, " byte count"}, n_rx, exp_n);
      for (int i = 0; i < exp_n && i < 8; i++) begin
         if (i == 0) chk("R3", {tag, " address byte"}, rx[i], exp_b[i]);
         else        chk("R4", {tag, " following byte"}, rx[i], exp_b[i]);
      end
      chk("R7", {tag, " min SCL high"}, hi_min, 2 * exp_d);
      chk("R7", {tag, " max SCL high"}, hi_max, 2 * exp_d);
      chk("R8", {tag, " done pulses"}, done_cnt, 1);
      chk("R8", {tag, " done after stop"}, done_cyc, stop_cyc + 1);
      chk("R8", {tag, " done while busy"}, done_busy, 0);
      chk("R6", {tag, " nack flag"}, nack, exp_nack);
      chk("R10", {tag, " lines idle"}, {scl_line, sda_line}, 2'b11);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0; start = 1'b0; sample = '0; dev_addr = '0; sub_addr = '0;
      sub_en = 1'b0; wide_en = 1'b0; div = '0;
      repeat (5) @(negedge clk);
      chk("R1", "scl released in reset", scl_oe, 0);
      chk("R1", "sda released in reset", sda_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy/done/nack after reset", {busy, done, nack}, 3'b000);
      repeat (50) @(negedge clk);
      chk("R10", "no SCL activity while idle", scl_line, 1);
   endtask

   task automatic t_sub_two();
      launch(7'h4C, 8'h31, 1'b1, 1'b1, 12'hA5C, 8'd20, -1);
      wait_done();
      verify("R4 sub+two");
   endtask

   task automatic t_one_clamp();
      launch(7'h60, 8'h00, 1'b0, 1'b0, 12'h7F3, 8'd1, -1);   // divider floor applies
      wait_done();
      verify("R7 one-byte clamp");
      chk("R5", "top bits only", rx[1], 8'h7F);
   endtask

   task automatic t_nosub_two();
      launch(7'h0F, 8'hAA, 1'b0, 1'b1, 12'h123, 8'd13, -1);
      wait_done();
      verify("R5 two no-sub");
   endtask

   task automatic t_sub_one();
      launch(7'h55, 8'hE7, 1'b1, 1'b0, 12'hFFF, 8'd16, -1);
      wait_done();
      verify("R4 sub+one");
   endtask

   task automatic t_nack_sub();
      launch(7'h4C, 8'h31, 1'b1, 1'b1, 12'hA5C, 8'd14, 1);
      wait_done();
      verify("R6 nack on sub");
   endtask

   task automatic t_nack_clear();
      launch(7'h0F, 8'hAA, 1'b0, 1'b1, 12'h321, 8'd13, -1);
      repeat (3) @(negedge clk);
      chk("R6", "nack cleared on accept", nack, 0);
      wait_done();
      verify("R6 after nack");
   endtask

   task automatic t_nack_addr();
      launch(7'h22, 8'h10, 1'b1, 1'b1, 12'h456, 8'd13, 0);
      wait_done();
      verify("R6 nack on address");
   endtask

   task automatic t_busy_ignore();
      launch(7'h0F, 8'h00, 1'b0, 1'b1, 12'h123, 8'd13, -1);
      repeat (200) @(negedge clk);
      sample = 12'hFFF; sub_en = 1'b1; wide_en = 1'b0; dev_addr = 7'h7F; div = 8'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      verify("R9 restart ignored");
      repeat (300) @(negedge clk);
      chk("R9", "no second frame", n_start, 1);
      chk("R10", "SCL idle after frame", scl_line, 1);
      chk("R10", "no done after frame", done_cnt, 1);
   endtask

   // ---------------- watchdog ----------------
   bit finished = 1'b0;
   initial begin
      repeat (150_000) @(posedge clk);
      if (!finished) begin
         n_checks = n_checks + 1;
         n_errors = n_errors + 1;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_sub_two();
      t_one_clamp();
      t_nosub_two();
      t_sub_one();
      t_nack_sub();
      t_nack_clear();
      t_nack_addr();
      t_busy_ignore();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule